// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This unit is the multi-cycle divide engine of a 32-bit processor. It divides a 64-bit dividend, made from a 32-bit upper-half register value and a 32-bit operand, by a 32-bit divisor. The operation can be signed or unsigned. The result is a 32-bit quotient that is clamped to the nearest representable value when the true quotient does not fit, together with an overflow flag. A zero divisor produces no result. It raises a divide-by-zero trap instead.

The unit uses a start/busy/done handshake. A request is accepted only while the unit is idle. The magnitudes are divided by a restoring shift-subtract loop that produces one quotient bit per cycle, and the sign is applied at the end. The requester can ask for a condition-code update. In that case the final quotient and overflow flag are also copied into a pair of flag-source registers.

Top module: `sat_div64`

## Requirements
- R1: The dividend is the concatenation {hi_word, lo_word}, with hi_word as the most significant 32 bits. In unsigned mode (op_signed=0) a quotient that fits in 32 bits is returned exactly, with ovf=0.
- R2: After reset is released, busy=0, done=0, dz_trap=0, ovf=0, quotient=0, cc_quot=0 and cc_ovf=0.
- R3: In unsigned mode, if the quotient exceeds 0xFFFFFFFF then quotient=0xFFFFFFFF and ovf=1. A quotient of exactly 0xFFFFFFFF is not an overflow.
- R4: In signed mode (op_signed=1) the dividend and the divisor are two's complement, and the quotient is truncated toward zero.
- R5: In signed mode, a quotient above 0x7FFFFFFF gives quotient=0x7FFFFFFF with ovf=1. A quotient below -2^31 gives quotient=0x80000000 with ovf=1. Exactly -2^31 is returned without overflow.
- R6: In signed mode, the most negative 64-bit dividend divided by -1 gives quotient=0x7FFFFFFF with ovf=1.
- R7: A zero divisor sets dz_trap=1 in the done cycle. The done cycle follows the first edge, counting the edge that accepts start as edge 1. In this case quotient, ovf, cc_quot and cc_ovf keep their previous values. A completed division clears dz_trap.
- R8: If cc_req=1 at start, a completed division copies the quotient and ovf into cc_quot and cc_ovf. If cc_req=0, these registers are not changed.
- R9: start is accepted only while busy=0. For a nonzero divisor, busy is high from the accepting edge, and done is high after edge 66 counting the accepting edge as edge 1. done lasts exactly one cycle. A start raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (sampled while idle) |
| op_signed | input | 1 | 1 = two's complement divide, 0 = unsigned |
| cc_req | input | 1 | 1 = copy result into the condition-code sources |
| hi_word | input | 32 | Upper half of the dividend |
| lo_word | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Saturated quotient, held until the next completion |
| ovf | output | 1 | Quotient was saturated |
| dz_trap | output | 1 | Last request had a zero divisor |
| cc_quot | output | 32 | Quotient latched for flag generation |
| cc_ovf | output | 1 | Overflow latched for flag generation |

## Verification
The bench targets the edges of each clamp: quotients of exactly 0xFFFFFFFF, exactly -2^31 and exactly +2^31. A design whose comparison is off by one would saturate a value that fits, or pass one through that does not. Mixed-sign operands are tested with remainders, to catch a design that rounds toward minus infinity instead of toward zero. The most negative dividend divided by -1 is tested to catch a design whose magnitude path wraps to a negative result. Zero divisors are placed just after completed results, to expose a design that disturbs the held quotient or flag registers. A second start is raised mid-run, to expose a design that restarts or finishes twice.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
// Operand preparation: dividend/divisor magnitudes, quotient sign, zero test.
module sdiv_prep #(
  parameter int DW = 32,
  localparam int QW = 2 * DW
) (
  input  logic          op_signed,
  input  logic [DW-1:0] hi_word,
  input  logic [DW-1:0] lo_word,
  input  logic [DW-1:0] divisor,
  output logic [QW-1:0] dvd_mag,
  output logic [DW-1:0] dvs_mag,
  output logic          q_neg,
  output logic          dvs_zero
);
  logic [QW-1:0] dvd_raw;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dvd_raw  = {hi_word, lo_word};
    dvd_neg  = op_signed & dvd_raw[QW-1];
    dvs_neg  = op_signed & divisor[DW-1];
    dvd_mag  = dvd_neg ? ((~dvd_raw) + QW'(1)) : dvd_raw;
    dvs_mag  = dvs_neg ? ((~divisor) + DW'(1)) : divisor;
    q_neg    = dvd_neg ^ dvs_neg;
    dvs_zero = (divisor == '0);
  end
endmodule

// File: rtl/sdiv_core.sv
// Restoring shift-subtract datapath, one quotient bit per enabled cycle.
module sdiv_core #(
  parameter int DW = 32,
  localparam int QW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_en,
  input  logic [QW-1:0] dvd_mag,
  input  logic [DW-1:0] dvs_mag,
  output logic [QW-1:0] q_mag
);
  logic [DW-1:0] rem_q, rem_d;
  logic [QW-1:0] acc_q, acc_d;
  logic [DW-1:0] dvs_q, dvs_d;
  logic [DW:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem_q, acc_q[QW-1]};
    fits  = (trial >= {1'b0, dvs_q});
    rem_d = rem_q;
    acc_d = acc_q;
    dvs_d = dvs_q;
    if (load) begin
      rem_d = '0;
      acc_d = dvd_mag;
      dvs_d = dvs_mag;
    end else if (step_en) begin
      rem_d = fits ? (trial[DW-1:0] - dvs_q) : trial[DW-1:0];
      acc_d = {acc_q[QW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      dvs_q <= '0;
    end else if (load || step_en) begin
      rem_q <= rem_d;
      acc_q <= acc_d;
      dvs_q <= dvs_d;
    end
  end

  assign q_mag = acc_q;
endmodule

// File: rtl/sdiv_sat.sv
// Sign application and 32-bit saturation of the quotient magnitude.
module sdiv_sat #(
  parameter int DW = 32,
  localparam int QW = 2 * DW
) (
  input  logic [QW-1:0] q_mag,
  input  logic          is_signed,
  input  logic          q_neg,
  output logic [DW-1:0] quot,
  output logic          sat
);
  localparam logic [DW-1:0] UMAX = '1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic hi_any;

  always_comb begin
    hi_any = |q_mag[QW-1:DW];
    if (!is_signed) begin
      sat  = hi_any;
      quot = sat ? UMAX : q_mag[DW-1:0];
    end else if (!q_neg) begin
      sat  = hi_any | q_mag[DW-1];
      quot = sat ? SMAX : q_mag[DW-1:0];
    end else begin
      sat  = hi_any | (q_mag[DW-1] & (|q_mag[DW-2:0]));
      quot = sat ? SMIN : ((~q_mag[DW-1:0]) + DW'(1));
    end
  end
endmodule

// File: rtl/sdiv_ctrl.sv
// Sequencer: idle / iterate / wrap-up, with the bit counter.
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int STEPS = 64,
  localparam int CW = $clog2(STEPS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dvs_zero,
  output logic load,
  output logic step_en,
  output logic finish,
  output logic trap_evt,
  output logic busy
);
  sdiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last;

  always_comb begin
    last     = (cnt_q == CW'(STEPS - 1));
    load     = (state_q == ST_IDLE) & start & ~dvs_zero;
    trap_evt = (state_q == ST_IDLE) & start &  dvs_zero;
    step_en  = (state_q == ST_RUN);
    finish   = (state_q == ST_WRAP);
    busy     = (state_q != ST_IDLE);
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (load) begin
        state_d = ST_RUN;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RUN: begin
        cnt_d  = cnt_q + CW'(1);
        cnt_en = 1'b1;
        if (last) state_d = ST_WRAP;
      end
      ST_WRAP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sat_div64.sv
module sat_div64 #(
  parameter int DW = 32,
  localparam int QW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_signed,
  input  logic          cc_req,
  input  logic [DW-1:0] hi_word,
  input  logic [DW-1:0] lo_word,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quotient,
  output logic          ovf,
  output logic          dz_trap,
  output logic [DW-1:0] cc_quot,
  output logic          cc_ovf
);
  logic [QW-1:0] dvd_mag;
  logic [DW-1:0] dvs_mag;
  logic          q_neg_c, dvs_zero;
  logic          load, step_en, finish, trap_evt;
  logic [QW-1:0] q_mag;
  logic [DW-1:0] sat_quot;
  logic          sat_flag;

  logic          mode_q, neg_q, ccsel_q;
  logic [DW-1:0] quot_q;
  logic          ovf_q, trap_q, done_q;
  logic [DW-1:0] ccq_q;
  logic          cco_q;

  sdiv_prep #(.DW(DW)) u_prep (
    .op_signed (op_signed),
    .hi_word   (hi_word),
    .lo_word   (lo_word),
    .divisor   (divisor),
    .dvd_mag   (dvd_mag),
    .dvs_mag   (dvs_mag),
    .q_neg     (q_neg_c),
    .dvs_zero  (dvs_zero)
  );

  sdiv_ctrl #(.STEPS(QW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dvs_zero (dvs_zero),
    .load     (load),
    .step_en  (step_en),
    .finish   (finish),
    .trap_evt (trap_evt),
    .busy     (busy)
  );

  sdiv_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step_en (step_en),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .q_mag   (q_mag)
  );

  sdiv_sat #(.DW(DW)) u_sat (
    .q_mag     (q_mag),
    .is_signed (mode_q),
    .q_neg     (neg_q),
    .quot      (sat_quot),
    .sat       (sat_flag)
  );

  // request attributes captured on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      neg_q   <= 1'b0;
      ccsel_q <= 1'b0;
    end else if (load) begin
      mode_q  <= op_signed;
      neg_q   <= q_neg_c;
      ccsel_q <= cc_req;
    end
  end

  // architectural result, held across traps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      ovf_q  <= 1'b0;
    end else if (finish) begin
      quot_q <= sat_quot;
      ovf_q  <= sat_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   trap_q <= 1'b0;
    else if (finish || trap_evt)  trap_q <= trap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish | trap_evt;
  end

  // condition-code sources
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccq_q <= '0;
      cco_q <= 1'b0;
    end else if (finish && ccsel_q) begin
      ccq_q <= sat_quot;
      cco_q <= sat_flag;
    end
  end

  assign done     = done_q;
  assign quotient = quot_q;
  assign ovf      = ovf_q;
  assign dz_trap  = trap_q;
  assign cc_quot  = ccq_q;
  assign cc_ovf   = cco_q;
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] quotient,
  input logic          ovf,
  input logic          dz_trap,
  input logic [DW-1:0] cc_quot,
  input logic          cc_ovf,
  input logic          mode_q,
  input logic          ccsel_q
);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_usat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && ovf && !mode_q) |-> (quotient == '1));

  p_ssat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && ovf && mode_q) |-> (quotient == SMAX || quotient == SMIN));

  p_trap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz_trap) |-> ($stable(quotient) && $stable(ovf)));

  p_cc_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cc_quot) || !$stable(cc_ovf)) |-> (done && !dz_trap && ccsel_q));
endmodule

bind sat_div64 sdiv_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .quotient (quotient),
  .ovf      (ovf),
  .dz_trap  (dz_trap),
  .cc_quot  (cc_quot),
  .cc_ovf   (cc_ovf),
  .mode_q   (mode_q),
  .ccsel_q  (ccsel_q)
);

// File: tb/tb_sat_div64.sv
module tb_sat_div64;
  logic        clk;
  logic        rst_n;
  logic        start, op_signed, cc_req;
  logic [31:0] hi_word, lo_word, divisor;
  logic        busy, done, ovf, dz_trap, cc_ovf;
  logic [31:0] quotient, cc_quot;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  sat_div64 dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed), .cc_req(cc_req),
    .hi_word(hi_word), .lo_word(lo_word), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .ovf(ovf), .dz_trap(dz_trap),
    .cc_quot(cc_quot), .cc_ovf(cc_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] hi, lo, d, input bit sgn,
                                output logic [31:0] q, output logic ov);
    logic [63:0] un, uq;
    longint sn, sd, sq;
    un = {hi, lo};
    ov = 1'b0;
    if (!sgn) begin
      uq = un / {32'd0, d};
      if (uq > 64'h0000_0000_FFFF_FFFF) begin q = 32'hFFFF_FFFF; ov = 1'b1; end
      else q = uq[31:0];
    end else begin
      sn = longint'(un);
      sd = longint'($signed(d));
      if (un == 64'h8000_0000_0000_0000 && sd == -1) begin
        q = 32'h7FFF_FFFF; ov = 1'b1;
      end else begin
        sq = sn / sd;
        if (sq > 64'sd2147483647)       begin q = 32'h7FFF_FFFF; ov = 1'b1; end
        else if (sq < -64'sd2147483648) begin q = 32'h8000_0000; ov = 1'b1; end
        else q = sq[31:0];
      end
    end
  endfunction

  // issue one request and verify result, flags, cc sources and latency
  task automatic run_op(input logic [31:0] hi, lo, d, input bit sgn, input bit cc, input string tag);
    logic [31:0] eq, pq, pcq;
    logic        eo, po, pco;
    bit          zero;
    int          lat;
    zero = (d == 32'd0);
    pq = quotient; po = ovf; pcq = cc_quot; pco = cc_ovf;
    if (zero) begin eq = pq; eo = po; end
    else model(hi, lo, d, sgn, eq, eo);
    @(negedge clk);
    hi_word = hi; lo_word = lo; divisor = d; op_signed = sgn; cc_req = cc; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 200);
    check(lat == (zero ? 1 : 66), {tag, " R9 latency"}, 64'(lat), zero ? 64'd1 : 64'd66);
    check(quotient == eq, {tag, " quotient"}, 64'(quotient), 64'(eq));
    check(ovf == eo, {tag, " ovf"}, 64'(ovf), 64'(eo));
    check(dz_trap == zero, {tag, " R7 trap"}, 64'(dz_trap), 64'(zero));
    if (cc && !zero) begin
      check(cc_quot == eq && cc_ovf == eo, {tag, " R8 cc update"}, {31'd0, cc_ovf, cc_quot}, {31'd0, eo, eq});
    end else begin
      check(cc_quot == pcq && cc_ovf == pco, {tag, " R8 cc held"}, {31'd0, cc_ovf, cc_quot}, {31'd0, pco, pcq});
    end
    @(negedge clk);
    check(!done && !busy, {tag, " R9 done pulse"}, {62'd0, done, busy}, 64'd0);
  endtask

  // second start while busy must be ignored
  task automatic busy_start_ignored();
    int lat, ndone;
    @(negedge clk);
    hi_word = 32'd0; lo_word = 32'd1000; divisor = 32'd10; op_signed = 1'b0; cc_req = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    repeat (10) @(negedge clk);
    hi_word = 32'd0; lo_word = 32'd999; divisor = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; divisor = 32'd3;
    lat = 12; ndone = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check(lat == 66, "R9 latency with stray start", 64'(lat), 64'd66);
    check(quotient == 32'd100 && !dz_trap, "R9 stray start ignored", {31'd0, dz_trap, quotient}, 64'd100);
    repeat (70) begin @(negedge clk); if (done) ndone++; end
    check(ndone == 0 && !busy, "R9 no second completion", 64'(ndone), 64'd0);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; op_signed = 1'b0; cc_req = 1'b0;
    hi_word = '0; lo_word = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !dz_trap && !ovf && quotient == 0 && cc_quot == 0 && !cc_ovf,
          "R2 reset state", {27'd0, busy, done, dz_trap, ovf, cc_ovf, quotient}, 64'd0);

    run_op(32'd0, 32'd100, 32'd7, 1'b0, 1'b0, "R1 small unsigned");
    run_op(32'd1, 32'd0, 32'd2, 1'b0, 1'b1, "R1 upper half used");
    run_op(32'h0000_0003, 32'h1234_5678, 32'h8000_0001, 1'b0, 1'b0, "R1 wide divisor");
    run_op(32'd5, 32'd0, 32'd3, 1'b0, 1'b1, "R3 unsigned saturate");
    run_op(32'hFFFF_FFFE, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1, "R3 exact max no ovf");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0, "R4 neg/pos truncation");
    run_op(32'd0, 32'd7, 32'hFFFF_FFFE, 1'b1, 1'b0, "R4 pos/neg truncation");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b1, "R4 neg/neg");
    run_op(32'd1, 32'd0, 32'd1, 1'b1, 1'b1, "R5 positive saturate");
    run_op(32'hFFFF_FFFE, 32'd0, 32'd1, 1'b1, 1'b1, "R5 negative saturate");
    run_op(32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R5 exact min no ovf");
    run_op(32'd0, 32'h8000_0000, 32'd1, 1'b1, 1'b0, "R5 plus 2^31 saturate");
    run_op(32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, "R6 min by minus one");
    run_op(32'd0, 32'd50, 32'd5, 1'b0, 1'b1, "R8 cc set");
    run_op(32'd0, 32'd77, 32'd0, 1'b0, 1'b1, "R7 zero divisor");
    run_op(32'd2, 32'd0, 32'd1, 1'b0, 1'b0, "R8 plain op keeps cc");
    run_op(32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1, 1'b1, "R7 signed zero divisor");
    run_op(32'd0, 32'd9, 32'd4, 1'b0, 1'b0, "R7 trap cleared by result");
    busy_start_ignored();

    for (int i = 0; i < 40; i++) begin
      logic [31:0] h, l, d;
      lfsr = next_rand(lfsr); h = lfsr;
      lfsr = next_rand(lfsr); l = lfsr;
      lfsr = next_rand(lfsr); d = lfsr;
      if (i % 3 == 0) h = {{24{h[31]}}, h[7:0]};
      if (i % 5 == 0) d = {16'd0, d[15:0]};
      if (d == 0) d = 32'd1;
      run_op(h, l, d, i[0], i[1], (i[0] ? "R4 random signed" : "R1 random unsigned"));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog expired: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule